// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This unit is the shift and rotate slice of an integer execution datapath. In one cycle it handles nine operations on a `WIDTH`-bit operand:

- left shift, logical right shift and arithmetic right shift;
- plain rotate left and right;
- rotate left and right through the carry bit;
- double-width left and right shifts, which take their fill bits from a second operand.

Alongside the result it produces new carry, overflow, sign, zero and parity flags. The incoming flag values are inputs, so every flag the operation does not define passes through unchanged.

The shift count is reduced to its low bits, so it is taken modulo the width. A reduced count of zero is a no-operation: the result equals the destination and all five flags keep their incoming values.

All next values are computed in one combinational pass and registered. Outputs therefore follow the inputs sampled at each rising clock edge, one cycle later.

Top module: `shrot_unit`

## Requirements
- R1: While `rst_n` is low every output reads zero; otherwise each output shows the result of the inputs sampled at the previous rising clock edge.
- R2: Only the low `CMASK_W` bits (default 6) of `cnt_i` are used, so at width 64 a count of 65 acts as 1 and a count of 64 acts as 0.
- R3: When the reduced count is zero, `res_o` equals `dst_i` and the five flag outputs equal the five flag inputs.
- R4: Operation code 0 (left shift) fills vacated low bits with zeros, and carry is the last bit moved out of the top.
- R5: Code 1 (logical right shift) fills with zeros and code 2 (arithmetic right shift) fills with the sign bit. For both, carry is the last bit moved out of the bottom, so -7 shifted arithmetically by 1 gives -4 with carry 1.
- R6: Code 3 (rotate left) and code 4 (rotate right) wrap bits to the other end. Carry copies the last bit that wrapped: the new bit 0 for a left rotate, the new top bit for a right rotate.
- R7: Code 5 (rotate left through carry) and code 6 (rotate right through carry) rotate the width+1 bit value {carry, operand} by the count modulo width+1. On a left rotate the old carry enters bit 0 and the old top bit becomes the carry.
- R8: Code 7 (double left shift) fills the vacated low bits from the top bits of `src_i`, and code 8 (double right shift) fills the vacated high bits from the bottom bits of `src_i`. Carry follows R4 and R5 respectively.
- R9: For a reduced count of 1, overflow is set as follows:
  - codes 0, 3, 5 and 7: new top bit XOR new carry;
  - codes 1 and 8: old top bit XOR new top bit;
  - code 2: 0;
  - codes 4 and 6: new top bit XOR new next-to-top bit.

  For counts above 1, overflow keeps its incoming value.
- R10: For a nonzero count, codes 0, 1, 2, 7 and 8 set sign to the result's top bit, zero to 1 when the result is all zeros, and parity to 1 when the result's low byte holds an even number of ones. Codes 3 to 6 pass sign, zero and parity through.
- R11: Codes 9 to 15 behave like a zero count: the result is the destination and all flags pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (0 to 8 as listed in the requirements) |
| dst_i | input | WIDTH | Operand that is shifted or rotated |
| src_i | input | WIDTH | Fill operand for the double shifts |
| cnt_i | input | CNT_IN_W | Shift count before reduction |
| cf_i | input | 1 | Incoming carry |
| of_i | input | 1 | Incoming overflow |
| sf_i | input | 1 | Incoming sign |
| zf_i | input | 1 | Incoming zero |
| pf_i | input | 1 | Incoming parity |
| res_o | output | WIDTH | Registered result |
| cf_o | output | 1 | Registered carry |
| of_o | output | 1 | Registered overflow |
| sf_o | output | 1 | Registered sign |
| zf_o | output | 1 | Registered zero |
| pf_o | output | 1 | Registered parity |

## Verification
Count reduction and the zero-count hold can act on the same operation: a count that is a nonzero multiple of 64 reduces to zero. The bench provokes this by issuing shifts and rotates with counts of 64 and 128 while the carry and other flag inputs are deliberately odd. It judges the outcome by requiring that result and flags equal the inputs exactly.

A second coincidence is a count of 1, where the carry and overflow rules fire together. Overflow depends on the new carry in the same cycle. This is checked for every operation against a bench model that rotates and shifts one bit at a time.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    // Operation codes; the numeric values are part of the port contract.
    typedef enum logic [3:0] {
        OP_SHL  = 4'd0,
        OP_SHR  = 4'd1,
        OP_SAR  = 4'd2,
        OP_ROL  = 4'd3,
        OP_ROR  = 4'd4,
        OP_RCL  = 4'd5,
        OP_RCR  = 4'd6,
        OP_DSHL = 4'd7,
        OP_DSHR = 4'd8
    } shrot_op_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic pf;
    } shrot_flags_t;

    // Even parity of a byte: 1 when the number of ones is even.
    function automatic logic even_par(input logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/shrot_count.sv
// Reduces the raw count and derives the reduced through-carry count.
module shrot_count #(
    parameter int WIDTH    = 64,
    parameter int CNT_IN_W = 8,
    parameter int CMASK_W  = 6
) (
    input  logic [CNT_IN_W-1:0] cnt_i,
    output logic [CMASK_W-1:0]  c_o,
    output logic [CMASK_W-1:0]  rc_o,
    output logic                c_zero_o,
    output logic                c_one_o,
    output logic                rc_zero_o,
    output logic                rc_one_o
);

    localparam int CMOD = 1 << CMASK_W;
    localparam int RMOD = WIDTH + 1;

    assign c_o = CMASK_W'(int'(cnt_i) % CMOD);

    generate
        if (CMOD - 1 < RMOD) begin : g_direct
            // Every reduced count is already below width+1.
            assign rc_o = c_o;
        end else begin : g_mod
            assign rc_o = CMASK_W'(int'(c_o) % RMOD);
        end
    endgenerate

    assign c_zero_o  = (c_o == '0);
    assign c_one_o   = (c_o == CMASK_W'(1));
    assign rc_zero_o = (rc_o == '0);
    assign rc_one_o  = (rc_o == CMASK_W'(1));

endmodule

// File: rtl/shrot_shift.sv
// Plain and double shifts. WIDTH is expected to be a power of two.
module shrot_shift #(
    parameter int WIDTH   = 64,
    parameter int CMASK_W = 6
) (
    input  logic [3:0]         op_i,
    input  logic [WIDTH-1:0]   dst_i,
    input  logic [WIDTH-1:0]   src_i,
    input  logic [CMASK_W-1:0] c_i,
    output logic [WIDTH-1:0]   res_o,
    output logic               cf_o
);
    import shrot_pkg::*;

    logic [CMASK_W-1:0]       idx_l;
    logic [CMASK_W-1:0]       idx_r;
    logic                     cf_left;
    logic                     cf_right;
    logic [WIDTH-1:0]         shl_v;
    logic [WIDTH-1:0]         shr_v;
    logic signed [WIDTH-1:0]  sar_v;
    logic [WIDTH-1:0]         dshl_v;
    logic [WIDTH-1:0]         dshr_v;

    // Last bit out of the top is dst[WIDTH-c]; out of the bottom is dst[c-1].
    assign idx_l    = CMASK_W'(WIDTH - int'(c_i));
    assign idx_r    = c_i - CMASK_W'(1);
    assign cf_left  = dst_i[idx_l];
    assign cf_right = dst_i[idx_r];

    assign shl_v  = dst_i << c_i;
    assign shr_v  = dst_i >> c_i;
    assign sar_v  = $signed(dst_i) >>> c_i;
    assign dshl_v = (dst_i << c_i) | (src_i >> (WIDTH - int'(c_i)));
    assign dshr_v = (dst_i >> c_i) | (src_i << (WIDTH - int'(c_i)));

    always_comb begin
        res_o = dst_i;
        cf_o  = 1'b0;
        case (op_i)
            OP_SHL:  begin res_o = shl_v;  cf_o = cf_left;  end
            OP_SHR:  begin res_o = shr_v;  cf_o = cf_right; end
            OP_SAR:  begin res_o = sar_v;  cf_o = cf_right; end
            OP_DSHL: begin res_o = dshl_v; cf_o = cf_left;  end
            OP_DSHR: begin res_o = dshr_v; cf_o = cf_right; end
            default: begin res_o = dst_i;  cf_o = 1'b0;     end
        endcase
    end

endmodule

// File: rtl/shrot_rotate.sv
// Plain rotates and rotates through the carry bit.
module shrot_rotate #(
    parameter int WIDTH   = 64,
    parameter int CMASK_W = 6
) (
    input  logic [3:0]         op_i,
    input  logic [WIDTH-1:0]   dst_i,
    input  logic               cf_i,
    input  logic [CMASK_W-1:0] c_i,
    input  logic [CMASK_W-1:0] rc_i,
    output logic [WIDTH-1:0]   res_o,
    output logic               cf_o
);
    import shrot_pkg::*;

    logic [WIDTH-1:0] rol_v;
    logic [WIDTH-1:0] ror_v;
    logic [WIDTH:0]   ext;
    logic [WIDTH:0]   rcl_v;
    logic [WIDTH:0]   rcr_v;

    assign rol_v = (dst_i << c_i) | (dst_i >> (WIDTH - int'(c_i)));
    assign ror_v = (dst_i >> c_i) | (dst_i << (WIDTH - int'(c_i)));

    // Carry sits above the operand to form one width+1 bit ring.
    assign ext   = {cf_i, dst_i};
    assign rcl_v = (ext << rc_i) | (ext >> (WIDTH + 1 - int'(rc_i)));
    assign rcr_v = (ext >> rc_i) | (ext << (WIDTH + 1 - int'(rc_i)));

    always_comb begin
        res_o = dst_i;
        cf_o  = cf_i;
        case (op_i)
            OP_ROL: begin res_o = rol_v; cf_o = rol_v[0];       end
            OP_ROR: begin res_o = ror_v; cf_o = ror_v[WIDTH-1]; end
            OP_RCL: begin res_o = rcl_v[WIDTH-1:0]; cf_o = rcl_v[WIDTH]; end
            OP_RCR: begin res_o = rcr_v[WIDTH-1:0]; cf_o = rcr_v[WIDTH]; end
            default: begin res_o = dst_i; cf_o = cf_i; end
        endcase
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
    parameter int WIDTH    = 64,
    parameter int CNT_IN_W = 8,
    parameter int CMASK_W  = $clog2(WIDTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          op_i,
    input  logic [WIDTH-1:0]    dst_i,
    input  logic [WIDTH-1:0]    src_i,
    input  logic [CNT_IN_W-1:0] cnt_i,
    input  logic                cf_i,
    input  logic                of_i,
    input  logic                sf_i,
    input  logic                zf_i,
    input  logic                pf_i,
    output logic [WIDTH-1:0]    res_o,
    output logic                cf_o,
    output logic                of_o,
    output logic                sf_o,
    output logic                zf_o,
    output logic                pf_o
);
    import shrot_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        shrot_flags_t     fl;
    } shrot_state_t;

    shrot_state_t st_d;
    shrot_state_t st_q;

    logic [CMASK_W-1:0] c_w;
    logic [CMASK_W-1:0] rc_w;
    logic               c_zero;
    logic               c_one;
    logic               rc_zero;
    logic               rc_one;
    logic [WIDTH-1:0]   sh_res;
    logic               sh_cf;
    logic [WIDTH-1:0]   rot_res;
    logic               rot_cf;

    shrot_count #(
        .WIDTH   (WIDTH),
        .CNT_IN_W(CNT_IN_W),
        .CMASK_W (CMASK_W)
    ) u_count (
        .cnt_i    (cnt_i),
        .c_o      (c_w),
        .rc_o     (rc_w),
        .c_zero_o (c_zero),
        .c_one_o  (c_one),
        .rc_zero_o(rc_zero),
        .rc_one_o (rc_one)
    );

    shrot_shift #(
        .WIDTH  (WIDTH),
        .CMASK_W(CMASK_W)
    ) u_shift (
        .op_i (op_i),
        .dst_i(dst_i),
        .src_i(src_i),
        .c_i  (c_w),
        .res_o(sh_res),
        .cf_o (sh_cf)
    );

    shrot_rotate #(
        .WIDTH  (WIDTH),
        .CMASK_W(CMASK_W)
    ) u_rotate (
        .op_i (op_i),
        .dst_i(dst_i),
        .cf_i (cf_i),
        .c_i  (c_w),
        .rc_i (rc_w),
        .res_o(rot_res),
        .cf_o (rot_cf)
    );

    always_comb begin
        st_d.res   = dst_i;
        st_d.fl.cf = cf_i;
        st_d.fl.of = of_i;
        st_d.fl.sf = sf_i;
        st_d.fl.zf = zf_i;
        st_d.fl.pf = pf_i;
        if (!c_zero) begin
            case (op_i)
                OP_SHL, OP_SHR, OP_SAR, OP_DSHL, OP_DSHR: begin
                    st_d.res   = sh_res;
                    st_d.fl.cf = sh_cf;
                    st_d.fl.sf = sh_res[WIDTH-1];
                    st_d.fl.zf = (sh_res == '0);
                    st_d.fl.pf = even_par(sh_res[7:0]);
                    if (c_one) begin
                        case (op_i)
                            OP_SHL, OP_DSHL: st_d.fl.of = sh_res[WIDTH-1] ^ sh_cf;
                            OP_SAR:          st_d.fl.of = 1'b0;
                            default:         st_d.fl.of = dst_i[WIDTH-1] ^ sh_res[WIDTH-1];
                        endcase
                    end
                end
                OP_ROL, OP_ROR: begin
                    st_d.res   = rot_res;
                    st_d.fl.cf = rot_cf;
                    if (c_one) begin
                        st_d.fl.of = (op_i == OP_ROL) ?
                                     (rot_res[WIDTH-1] ^ rot_cf) :
                                     (rot_res[WIDTH-1] ^ rot_res[WIDTH-2]);
                    end
                end
                OP_RCL, OP_RCR: begin
                    if (!rc_zero) begin
                        st_d.res   = rot_res;
                        st_d.fl.cf = rot_cf;
                        if (rc_one) begin
                            st_d.fl.of = (op_i == OP_RCL) ?
                                         (rot_res[WIDTH-1] ^ rot_cf) :
                                         (rot_res[WIDTH-1] ^ rot_res[WIDTH-2]);
                        end
                    end
                end
                default: begin
                    st_d.res = dst_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = st_q.res;
    assign cf_o  = st_q.fl.cf;
    assign of_o  = st_q.fl.of;
    assign sf_o  = st_q.fl.sf;
    assign zf_o  = st_q.fl.zf;
    assign pf_o  = st_q.fl.pf;

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
    parameter int WIDTH    = 64,
    parameter int CNT_IN_W = 8,
    parameter int CMASK_W  = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          op_i,
    input logic [WIDTH-1:0]    dst_i,
    input logic [CNT_IN_W-1:0] cnt_i,
    input logic                cf_i,
    input logic                of_i,
    input logic                sf_i,
    input logic                zf_i,
    input logic                pf_i,
    input logic [WIDTH-1:0]    res_o,
    input logic                cf_o,
    input logic                of_o,
    input logic                sf_o,
    input logic                zf_o,
    input logic                pf_o
);

    localparam int CMOD = 1 << CMASK_W;

    logic cnt_nz;
    logic cnt_big;
    assign cnt_nz  = ((int'(cnt_i) % CMOD) != 0);
    assign cnt_big = ((int'(cnt_i) % CMOD) > 1);

    // R3
    zero_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_nz |=> (res_o == $past(dst_i)) && (cf_o == $past(cf_i)) &&
                    (of_o == $past(of_i)) && (sf_o == $past(sf_i)) &&
                    (zf_o == $past(zf_i)) && (pf_o == $past(pf_i)));

    // R11
    bad_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd8) |=> (res_o == $past(dst_i)) && (cf_o == $past(cf_i)) &&
                          (of_o == $past(of_i)) && (zf_o == $past(zf_i)));

    // R4
    shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 && cnt_nz) |=> (res_o[0] == 1'b0));

    // R5
    sar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2) |=> (res_o[WIDTH-1] == $past(dst_i[WIDTH-1])));

    // R6
    rol_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3 && cnt_nz) |=> (cf_o == res_o[0]));

    // R6
    ror_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 && cnt_nz) |=> (cf_o == res_o[WIDTH-1]));

    // R10
    rot_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd3 && op_i <= 4'd6) |=>
            (sf_o == $past(sf_i)) && (zf_o == $past(zf_i)) && (pf_o == $past(pf_i)));

    // R10
    shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_nz && (op_i <= 4'd2 || op_i == 4'd7 || op_i == 4'd8)) |=>
            (zf_o == (res_o == '0)) && (sf_o == res_o[WIDTH-1]));

    // R9
    of_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_big && (op_i <= 4'd4 || op_i == 4'd7 || op_i == 4'd8)) |=>
            (of_o == $past(of_i)));

endmodule

bind shrot_unit shrot_unit_chk #(
    .WIDTH   (WIDTH),
    .CNT_IN_W(CNT_IN_W),
    .CMASK_W (CMASK_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .op_i (op_i),
    .dst_i(dst_i),
    .cnt_i(cnt_i),
    .cf_i (cf_i),
    .of_i (of_i),
    .sf_i (sf_i),
    .zf_i (zf_i),
    .pf_i (pf_i),
    .res_o(res_o),
    .cf_o (cf_o),
    .of_o (of_o),
    .sf_o (sf_o),
    .zf_o (zf_o),
    .pf_o (pf_o)
);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;

    localparam int W          = 64;
    localparam int CW         = 8;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [W-1:0] res;
        logic         cf, of, sf, zf, pf;
        string        tag;
    } exp_t;

    logic          clk;
    logic          rst_n;
    logic [3:0]    op_i;
    logic [W-1:0]  dst_i, src_i;
    logic [CW-1:0] cnt_i;
    logic          cf_i, of_i, sf_i, zf_i, pf_i;
    logic [W-1:0]  res_o;
    logic          cf_o, of_o, sf_o, zf_o, pf_o;

    int   checks   = 0;
    int   failures = 0;
    bit   done     = 0;
    exp_t sb[$];

    shrot_unit #(.WIDTH(W), .CNT_IN_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
        .cnt_i(cnt_i), .cf_i(cf_i), .of_i(of_i), .sf_i(sf_i), .zf_i(zf_i),
        .pf_i(pf_i), .res_o(res_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o),
        .zf_o(zf_o), .pf_o(pf_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // Bit-at-a-time reference built from the requirements.
    function automatic exp_t model(input logic [3:0] op, input logic [W-1:0] d,
                                   input logic [W-1:0] s, input logic [CW-1:0] n,
                                   input logic ci, input logic oi, input logic si,
                                   input logic zi, input logic pi);
        exp_t e;
        int c, rc;
        logic [W-1:0] r, t;
        logic cy, b;
        e.res = d; e.cf = ci; e.of = oi; e.sf = si; e.zf = zi; e.pf = pi; e.tag = "";
        c = int'(n) % W;
        if (c == 0 || op > 4'd8) return e;
        rc = (op == 4'd5 || op == 4'd6) ? c % (W + 1) : c;
        if (rc == 0) return e;
        r = d; t = s; cy = ci;
        for (int i = 0; i < rc; i++) begin
            case (op)
                4'd0: begin cy = r[W-1]; r = {r[W-2:0], 1'b0}; end
                4'd1: begin cy = r[0]; r = {1'b0, r[W-1:1]}; end
                4'd2: begin cy = r[0]; r = {r[W-1], r[W-1:1]}; end
                4'd3: begin b = r[W-1]; r = {r[W-2:0], b}; cy = b; end
                4'd4: begin b = r[0]; r = {b, r[W-1:1]}; cy = b; end
                4'd5: begin b = r[W-1]; r = {r[W-2:0], cy}; cy = b; end
                4'd6: begin b = r[0]; r = {cy, r[W-1:1]}; cy = b; end
                4'd7: begin cy = r[W-1]; r = {r[W-2:0], t[W-1]}; t = t << 1; end
                default: begin cy = r[0]; r = {t[0], r[W-1:1]}; t = t >> 1; end
            endcase
        end
        e.res = r;
        e.cf  = cy;
        if (rc == 1) begin
            case (op)
                4'd0, 4'd3, 4'd5, 4'd7: e.of = r[W-1] ^ cy;
                4'd1, 4'd8:             e.of = d[W-1] ^ r[W-1];
                4'd2:                   e.of = 1'b0;
                default:                e.of = r[W-1] ^ r[W-2];
            endcase
        end
        if (op <= 4'd2 || op >= 4'd7) begin
            e.sf = r[W-1];
            e.zf = (r == '0);
            e.pf = ~^r[7:0];
        end
        return e;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [W-1:0] d,
                         input logic [W-1:0] s, input logic [CW-1:0] n,
                         input logic [4:0] fl, input string tag);
        exp_t e;
        @(negedge clk);
        op_i = op; dst_i = d; src_i = s; cnt_i = n;
        {cf_i, of_i, sf_i, zf_i, pf_i} = fl;
        e = model(op, d, s, n, fl[4], fl[3], fl[2], fl[1], fl[0]);
        e.tag = tag;
        @(posedge clk);
        sb.push_back(e);
    endtask

    // Monitor: each item became visible after the posedge that followed its drive.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (res_o !== e.res || {cf_o, of_o, sf_o, zf_o, pf_o} !==
                {e.cf, e.of, e.sf, e.zf, e.pf}) begin
                failures++;
                $display("FAIL %s: res=%h flags(c,o,s,z,p)=%b expected res=%h flags=%b",
                         e.tag, res_o, {cf_o, of_o, sf_o, zf_o, pf_o}, e.res,
                         {e.cf, e.of, e.sf, e.zf, e.pf});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        op_i = 4'd0; dst_i = '1; src_i = '0; cnt_i = 8'd1;
        {cf_i, of_i, sf_i, zf_i, pf_i} = 5'b11111;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero in reset
        checks++;
        if (res_o !== '0 || {cf_o, of_o, sf_o, zf_o, pf_o} !== 5'b0) begin
            failures++;
            $display("FAIL R1 reset: res=%h flags=%b expected res=0 flags=00000",
                     res_o, {cf_o, of_o, sf_o, zf_o, pf_o});
        end
        rst_n = 1'b1;

        drive(4'd0, 64'h8000_0000_0000_0001, '0, 8'd1, 5'b00000, "R4 shl by 1");
        drive(4'd0, 64'hF0F0_0000_0000_1234, '0, 8'd4, 5'b01000, "R4 shl by 4 keeps of R9");
        drive(4'd1, 64'h8000_0000_0000_0003, '0, 8'd1, 5'b00000, "R5 shr by 1 R9");
        drive(4'd2, 64'hFFFF_FFFF_FFFF_FFF9, '0, 8'd1, 5'b01000, "R5 sar -7 by 1");
        drive(4'd2, 64'h8000_0000_0000_0000, '0, 8'd63, 5'b00000, "R5 sar by 63");
        drive(4'd0, 64'h0000_0000_0000_00FF, '0, 8'd65, 5'b00000, "R2 count 65 acts as 1");
        drive(4'd1, 64'h1234_5678_9ABC_DEF0, '0, 8'd64, 5'b10101, "R2 count 64 is zero R3");
        drive(4'd5, 64'h0123_4567_89AB_CDEF, '0, 8'd128, 5'b01011, "R3 zero count rcl");
        drive(4'd3, 64'h0123_4567_89AB_CDEF, '0, 8'd0, 5'b11111, "R3 zero count rol");
        drive(4'd3, 64'h8100_0000_0000_0000, '0, 8'd8, 5'b00111, "R6 rol by 8");
        drive(4'd4, 64'h0000_0000_0000_0081, '0, 8'd1, 5'b00000, "R6 ror by 1");
        drive(4'd5, 64'h8000_0000_0000_0000, '0, 8'd1, 5'b10000, "R7 rcl by 1");
        drive(4'd6, 64'h0000_0000_0000_0001, '0, 8'd63, 5'b10000, "R7 rcr by 63");
        drive(4'd7, 64'h1234_5678_9ABC_DEF0, 64'hA000_0000_0000_0000, 8'd4, 5'b00000, "R8 dshl by 4");
        drive(4'd8, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_000B, 8'd4, 5'b00000, "R8 dshr by 4");
        drive(4'd1, 64'h0000_0000_0000_0001, '0, 8'd1, 5'b00000, "R10 shr to zero");
        drive(4'd12, 64'hDEAD_BEEF_0000_0001, '0, 8'd5, 5'b10110, "R11 unused code");

        for (int op = 0; op < 9; op++) begin
            for (int k = 0; k < 150; k++) begin
                logic [W-1:0] d, s;
                logic [CW-1:0] n;
                d = {$urandom(), $urandom()};
                s = {$urandom(), $urandom()};
                n = (k < 8) ? CW'(k * 64 + (k % 2)) : CW'($urandom());
                drive(4'(op), d, s, n, 5'($urandom()), "R9 R10 mixed sweep");
            end
        end

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule